// File: doc/BRIEF.md
# SMBus Slave Write Receiver with PEC Detection

This block sits between a bit-level two-wire engine and a message consumer in an SMBus slave. The engine reports one event per cycle: an address match with write, an address match with read, a received byte, or a STOP. The block answers each event with an ACK/NACK decision in the same cycle. It runs the write transaction through its states and captures the command byte and the data bytes. When the message completes cleanly, it hands it to a consumer.

The message length is not fixed. A word command expects two data bytes. A block command takes its data length from the byte that follows the command. A signed expected-byte counter is loaded without the PEC byte and counts down once per stored byte. At STOP, a counter value of 0 means no PEC was sent. A value of -1 means the last stored byte is a PEC byte. Any other value is a protocol error.

While a finished message waits for the consumer, the block still acknowledges its own address. It then refuses every byte that follows until STOP. A master is therefore held off without stretching the clock. This also applies to a master read, because the read begins with a command byte, which is refused.

States:
- `ST_IDLE`: no transaction in progress.
- `ST_CMD`: waiting for the command byte.
- `ST_COUNT`: waiting for the block length byte.
- `ST_DATA`: receiving data bytes and the optional PEC byte.
- `ST_HOLD`: refusing bytes until STOP.

Transitions:
- `ST_IDLE`→`ST_CMD`: address-write while no message is pending.
- `ST_IDLE`→`ST_HOLD`: address-write while a message is pending.
- `ST_CMD`→`ST_DATA`: word command.
- `ST_CMD`→`ST_COUNT`: block command.
- `ST_CMD`→`ST_HOLD`: command out of range.
- `ST_COUNT`→`ST_DATA`: valid length byte.
- `ST_COUNT`→`ST_HOLD`: bad length byte.
- `ST_CMD`, `ST_COUNT` or `ST_DATA` →`ST_IDLE`: on STOP, with acceptance or an error; on an address event, with a fault request.
- `ST_HOLD`→`ST_IDLE`: on STOP.

Top module: `smb_write_rx`

## Requirements
- R1: After reset, `msg_valid`, `err_proto` and `fault_req` are 0, and `ev_ack` is 0 whenever `ev_valid` is 0.
- R2: In `ST_IDLE`, an address-write event (`ev_kind`=0) is ACKed, and the next byte is taken as the command. The encodings are: 0 = address-write, 1 = address-read, 2 = byte, 3 = STOP. Command bytes 0x00–0x3F are ACKed.
- R3: Commands 0x00–0x1F are word commands. After two data bytes, STOP completes a message with `msg_len`=2 and `msg_pec`=0. After three bytes, STOP completes a message with `msg_len`=2 and `msg_pec`=1, and the third byte is readable at index 2.
- R4: Commands 0x20–0x3F are block commands. The next byte N (1–32) is ACKed and sets the number of data bytes. STOP then completes a message with `msg_len`=N and with or without PEC; the PEC byte is readable at index N. This holds up to N=32 with PEC.
- R5: Once the counter has reached -1, a further data byte is NACKed and not stored, and the STOP that follows raises `err_proto` instead of a message.
- R6: A STOP in `ST_CMD`, `ST_COUNT`, or in `ST_DATA` with a counter other than 0 or -1, raises `err_proto` for one cycle, the cycle after STOP, and produces no message.
- R7: A command byte above 0x3F is NACKed and raises `err_proto` for one cycle. All bytes until STOP are NACKed, and no message results.
- R8: A block length byte of 0 or above 32 is NACKed and raises `err_proto`. The bytes that follow are NACKed until STOP.
- R9: While `msg_valid` is 1, an address event is still ACKed, and every byte that follows is NACKed until STOP. This covers the command byte of a read attempt. The pending message is left unchanged.
- R10: `msg_valid` rises the cycle after the accepting STOP and stays 1, with stable fields, until `msg_done`. It is 0 the cycle after `msg_done`, after which new messages are accepted again.
- R11: A STOP in `ST_IDLE` raises neither `err_proto` nor `fault_req`.
- R12: A byte or an address-read event in `ST_IDLE` is NACKed and raises `fault_req` for one cycle; the state stays `ST_IDLE`.
- R13: An address event in `ST_CMD`, `ST_COUNT` or `ST_DATA` raises `fault_req` for one cycle and returns the block to `ST_IDLE` without a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 2 | 0 = address-write, 1 = address-read, 2 = byte, 3 = STOP |
| ev_byte | input | 8 | Received byte for byte events |
| ev_ack | output | 1 | ACK decision for the current event (1 = ACK) |
| msg_valid | output | 1 | A completed message is pending |
| msg_cmd | output | 8 | Command byte of the pending message |
| msg_len | output | 6 | Data byte count, PEC excluded |
| msg_pec | output | 1 | The pending message carried a PEC byte |
| rd_idx | input | 6 | Read index into the stored data bytes |
| rd_data | output | 8 | Stored byte at `rd_idx` |
| msg_done | input | 1 | The consumer has finished with the message |
| err_proto | output | 1 | One-cycle protocol error pulse |
| fault_req | output | 1 | One-cycle unexpected-event pulse that requests bus-timeout recovery |

## Verification
The assertions assume the following about the inputs:
- At most one event arrives per cycle, as a single-cycle `ev_valid` pulse.
- `ev_kind` is meaningful only while `ev_valid` is 1.
- `msg_done` is raised only while `msg_valid` is 1, and never in the same cycle as an address event.

The stimulus drives every event as one pulse from a task. It raises `msg_done` only after reading back a pending message. This keeps the busy-hold assertions and the field-stability checks within those assumptions.

// File: rtl/smbw_pkg.sv
package smbw_pkg;
    typedef enum logic [1:0] {
        EV_ADDR_W = 2'd0,
        EV_ADDR_R = 2'd1,
        EV_BYTE   = 2'd2,
        EV_STOP   = 2'd3
    } ev_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_COUNT = 3'd2,
        ST_DATA  = 3'd3,
        ST_HOLD  = 3'd4
    } rx_state_t;
endpackage

// File: rtl/smbw_expect.sv
module smbw_expect #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-2:0] load_val,
    input  logic             dec,
    output logic             room,
    output logic             at_zero,
    output logic             at_neg1
);
    localparam logic signed [CNT_W-1:0] NEG2 = -2;
    localparam logic signed [CNT_W-1:0] NEG1 = -1;

    logic signed [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= $signed({1'b0, load_val});
        else if (dec && cnt_q != NEG2)
            cnt_q <= cnt_q - 1'b1;
    end

    assign room    = !cnt_q[CNT_W-1];
    assign at_zero = (cnt_q == '0);
    assign at_neg1 = (cnt_q == NEG1);

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q >= NEG2); // R5
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == NEG2 && dec && !load) |=> cnt_q == NEG2); // R5
endmodule

// File: rtl/smbw_store.sv
module smbw_store #(
    parameter int DEPTH = 33,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    assign rd_data = (rd_idx < IDX_W'(DEPTH)) ? mem[rd_idx] : 8'h00;

    AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < IDX_W'(DEPTH)); // R4
endmodule

// File: rtl/smb_write_rx.sv
module smb_write_rx
    import smbw_pkg::*;
#(
    parameter int         MAX_BLK    = 32,
    parameter int         WORD_LEN   = 2,
    parameter logic [7:0] CMD_MAX    = 8'h3F,
    parameter logic [7:0] BLK_CMD_LO = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_valid,
    input  logic [1:0] ev_kind,
    input  logic [7:0] ev_byte,
    output logic       ev_ack,
    output logic       msg_valid,
    output logic [7:0] msg_cmd,
    output logic [5:0] msg_len,
    output logic       msg_pec,
    input  logic [5:0] rd_idx,
    output logic [7:0] rd_data,
    input  logic       msg_done,
    output logic       err_proto,
    output logic       fault_req
);
    localparam int DEPTH = MAX_BLK + 1;
    localparam int IDX_W = $clog2(DEPTH + 1);
    localparam int LEN_W = $clog2(MAX_BLK + 1);
    localparam int CNT_W = $clog2(MAX_BLK + 1) + 2;

    ev_kind_t  kind;
    rx_state_t st_q, st_d;

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       cmd_q;
    logic [LEN_W-1:0] len_q;
    logic             pend_q, pec_q, err_q, fault_q;

    logic cnt_load, cnt_dec, cnt_room, cnt_zero, cnt_neg1;
    logic wr_en, cmd_we, idx_clr, accept, err_d, fault_d;
    logic [CNT_W-2:0] cnt_init;

    assign kind = ev_kind_t'(ev_kind);

    assign cnt_init = (st_q == ST_CMD) ? (CNT_W-1)'(WORD_LEN) : ev_byte[CNT_W-2:0];

    smbw_expect #(.CNT_W(CNT_W)) u_expect (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_init),
        .dec      (cnt_dec),
        .room     (cnt_room),
        .at_zero  (cnt_zero),
        .at_neg1  (cnt_neg1)
    );

    smbw_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_data (ev_byte),
        .rd_idx  (IDX_W'(rd_idx)),
        .rd_data (rd_data)
    );

    // next state and per-event decisions
    always_comb begin
        st_d     = st_q;
        ev_ack   = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        wr_en    = 1'b0;
        cmd_we   = 1'b0;
        idx_clr  = 1'b0;
        accept   = 1'b0;
        err_d    = 1'b0;
        fault_d  = 1'b0;
        if (ev_valid) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (kind == EV_ADDR_W) begin
                        ev_ack  = 1'b1;
                        idx_clr = 1'b1;
                        st_d    = pend_q ? ST_HOLD : ST_CMD;
                    end else if (kind != EV_STOP) begin
                        fault_d = 1'b1;
                    end
                end
                ST_CMD: begin
                    if (kind == EV_BYTE) begin
                        if (ev_byte > CMD_MAX) begin
                            err_d = 1'b1;
                            st_d  = ST_HOLD;
                        end else begin
                            ev_ack = 1'b1;
                            cmd_we = 1'b1;
                            if (ev_byte >= BLK_CMD_LO) begin
                                st_d = ST_COUNT;
                            end else begin
                                cnt_load = 1'b1;
                                st_d     = ST_DATA;
                            end
                        end
                    end else if (kind == EV_STOP) begin
                        err_d = 1'b1;
                        st_d  = ST_IDLE;
                    end else begin
                        fault_d = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end
                ST_COUNT: begin
                    if (kind == EV_BYTE) begin
                        if (ev_byte == 8'h00 || ev_byte > 8'(MAX_BLK)) begin
                            err_d = 1'b1;
                            st_d  = ST_HOLD;
                        end else begin
                            ev_ack   = 1'b1;
                            cnt_load = 1'b1;
                            st_d     = ST_DATA;
                        end
                    end else if (kind == EV_STOP) begin
                        err_d = 1'b1;
                        st_d  = ST_IDLE;
                    end else begin
                        fault_d = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (kind == EV_BYTE) begin
                        cnt_dec = 1'b1;
                        if (cnt_room) begin
                            ev_ack = 1'b1;
                            wr_en  = 1'b1;
                        end
                    end else if (kind == EV_STOP) begin
                        if (cnt_zero || cnt_neg1)
                            accept = 1'b1;
                        else
                            err_d = 1'b1;
                        st_d = ST_IDLE;
                    end else begin
                        fault_d = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end
                ST_HOLD: begin
                    if (kind == EV_ADDR_W || kind == EV_ADDR_R)
                        ev_ack = 1'b1;
                    else if (kind == EV_STOP)
                        st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state and message registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            cmd_q   <= '0;
            len_q   <= '0;
            pec_q   <= 1'b0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            err_q   <= err_d;
            fault_q <= fault_d;
            if (idx_clr)
                idx_q <= '0;
            else if (wr_en)
                idx_q <= idx_q + 1'b1;
            if (cmd_we)
                cmd_q <= ev_byte;
            if (accept) begin
                pend_q <= 1'b1;
                pec_q  <= cnt_neg1;
                len_q  <= LEN_W'(idx_q - IDX_W'(cnt_neg1));
            end else if (msg_done) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign msg_valid = pend_q;
    assign msg_cmd   = cmd_q;
    assign msg_len   = 6'(len_q);
    assign msg_pec   = pec_q;
    assign err_proto = err_q;
    assign fault_req = fault_q;

    AST_ADDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && kind == EV_ADDR_W && st_q == ST_IDLE) |-> ev_ack); // R9
    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && ev_valid && kind == EV_BYTE) |-> !ev_ack); // R9
    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_done) |=> (msg_valid && $stable(msg_cmd)
                                      && $stable(msg_len) && $stable(msg_pec))); // R10
    AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_done) |=> !msg_valid); // R10
    AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && ev_valid && kind == EV_STOP) |=> (!err_proto && !fault_req)); // R11
    AST_ACCEPT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (!err_proto && !fault_req)); // R6
    AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_len <= 6'(MAX_BLK)); // R4
endmodule

// File: tb/test_smb_write_rx.sv
module test_smb_write_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [1:0] ev_kind = 2'd0;
    logic [7:0] ev_byte = 8'h00;
    logic       ev_ack, msg_valid, msg_pec, err_proto, fault_req;
    logic [7:0] msg_cmd, rd_data;
    logic [5:0] msg_len;
    logic [5:0] rd_idx = 6'd0;
    logic       msg_done = 1'b0;

    localparam logic [1:0] K_AW = 2'd0, K_AR = 2'd1, K_BY = 2'd2, K_SP = 2'd3;

    always #5 clk = ~clk;

    smb_write_rx i_smb_write_rx (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_byte(ev_byte), .ev_ack(ev_ack), .msg_valid(msg_valid),
        .msg_cmd(msg_cmd), .msg_len(msg_len), .msg_pec(msg_pec),
        .rd_idx(rd_idx), .rd_data(rd_data), .msg_done(msg_done),
        .err_proto(err_proto), .fault_req(fault_req)
    );

    int    nchk = 0;
    int    nfail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference: 0 idle, 1 cmd, 2 count, 3 data, 4 hold
    int         m_st = 0;
    int         m_cnt = 0;
    logic [7:0] m_q[$];
    logic [7:0] m_msg[$];
    logic [7:0] m_cmd = 0;
    int         m_len = 0;
    bit         m_pec = 0, m_pend = 0, m_err = 0, m_fault = 0;

    function automatic bit exp_ack();
        if (!ev_valid || ev_kind == K_SP) return 0;
        case (m_st)
            0: return ev_kind == K_AW;
            1: return ev_kind == K_BY && ev_byte <= 8'h3F;
            2: return ev_kind == K_BY && ev_byte >= 1 && ev_byte <= 32;
            3: return ev_kind == K_BY && m_cnt >= 0;
            default: return ev_kind != K_BY;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pend = 0; m_err = 0; m_fault = 0;
            m_q.delete(); m_msg.delete();
        end else begin
            bit old_p;
            old_p = m_pend;
            m_err = 0; m_fault = 0;
            if (ev_valid) begin
                case (m_st)
                    0: if (ev_kind == K_AW) begin m_q.delete(); m_st = old_p ? 4 : 1; end
                       else if (ev_kind != K_SP) m_fault = 1;
                    1: if (ev_kind == K_BY) begin
                           if (ev_byte > 8'h3F) begin m_err = 1; m_st = 4; end
                           else begin
                               m_cmd = ev_byte;
                               if (ev_byte >= 8'h20) m_st = 2;
                               else begin m_cnt = 2; m_st = 3; end
                           end
                       end else if (ev_kind == K_SP) begin m_err = 1; m_st = 0; end
                       else begin m_fault = 1; m_st = 0; end
                    2: if (ev_kind == K_BY) begin
                           if (ev_byte == 0 || ev_byte > 32) begin m_err = 1; m_st = 4; end
                           else begin m_cnt = ev_byte; m_st = 3; end
                       end else if (ev_kind == K_SP) begin m_err = 1; m_st = 0; end
                       else begin m_fault = 1; m_st = 0; end
                    3: if (ev_kind == K_BY) begin
                           if (m_cnt >= 0) begin m_q.push_back(ev_byte); m_cnt--; end
                           else m_cnt = -2;
                       end else if (ev_kind == K_SP) begin
                           if (m_cnt == 0 || m_cnt == -1) begin
                               m_pend = 1; m_msg = m_q; m_pec = (m_cnt == -1);
                               m_len = m_q.size() - (m_cnt == -1 ? 1 : 0);
                           end else m_err = 1;
                           m_st = 0;
                       end else begin m_fault = 1; m_st = 0; end
                    default: if (ev_kind == K_SP) m_st = 0;
                endcase
            end
            if (msg_done && old_p) m_pend = 0;
        end
    end

    task automatic chk(bit ok, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(ev_ack == exp_ack(), "ev_ack", ev_ack, exp_ack());
            chk(msg_valid == m_pend, "msg_valid", msg_valid, m_pend);
            chk(err_proto == m_err, "err_proto", err_proto, m_err);
            chk(fault_req == m_fault, "fault_req", fault_req, m_fault);
            if (m_pend) begin
                chk(msg_cmd == m_cmd, "msg_cmd", msg_cmd, m_cmd);
                chk(msg_len == 6'(m_len), "msg_len", msg_len, m_len);
                chk(msg_pec == m_pec, "msg_pec", msg_pec, m_pec);
                if (rd_idx < m_msg.size())
                    chk(rd_data == m_msg[rd_idx], "rd_data", rd_data, m_msg[rd_idx]);
            end
        end
    end

    task automatic send(logic [1:0] k, logic [7:0] b);
        ev_valid = 1'b1; ev_kind = k; ev_byte = b;
        @(posedge clk); #1;
        ev_valid = 1'b0;
    endtask

    task automatic gap(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic drain();
        for (int i = 0; i < m_msg.size(); i++) begin
            rd_idx = 6'(i);
            gap(1);
        end
        msg_done = 1'b1;
        gap(1);
        msg_done = 1'b0;
        rd_idx = 6'd0;
        gap(1);
    endtask

    task automatic word_msg(logic [7:0] c, int nbytes);
        send(K_AW, 8'h16);
        send(K_BY, c);
        for (int i = 0; i < nbytes; i++) send(K_BY, 8'(i * 37 + 5));
        send(K_SP, 8'h00);
        gap(1);
    endtask

    task automatic block_msg(logic [7:0] c, logic [7:0] n, int nbytes);
        send(K_AW, 8'h16);
        send(K_BY, c);
        send(K_BY, n);
        for (int i = 0; i < nbytes; i++) send(K_BY, 8'(i * 11 + 9));
        send(K_SP, 8'h00);
        gap(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nfail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        gap(3);
        rst_n = 1'b1;
        gap(1);
        chk(msg_valid == 0 && err_proto == 0 && fault_req == 0, "reset outputs R1",
            {msg_valid, err_proto, fault_req}, 0);
        gap(2);

        cur_req = "R11"; send(K_SP, 0); gap(2);

        cur_req = "R2"; word_msg(8'h09, 2);
        cur_req = "R3"; drain();
        cur_req = "R3"; word_msg(8'h1F, 3); drain();

        cur_req = "R4"; block_msg(8'h20, 8'd4, 4); drain();
        cur_req = "R4"; block_msg(8'h3F, 8'd32, 33); drain();
        cur_req = "R4"; block_msg(8'h25, 8'd1, 2); drain();

        cur_req = "R5"; word_msg(8'h03, 4);
        cur_req = "R5"; block_msg(8'h21, 8'd2, 6);

        cur_req = "R6"; word_msg(8'h04, 1);
        cur_req = "R6"; word_msg(8'h04, 0);
        cur_req = "R6";
        send(K_AW, 8'h16); send(K_BY, 8'h30); send(K_SP, 0); gap(1);
        cur_req = "R6"; block_msg(8'h30, 8'd5, 3);

        cur_req = "R7"; word_msg(8'h40, 3);
        cur_req = "R7"; word_msg(8'hFF, 1);

        cur_req = "R8"; block_msg(8'h22, 8'd0, 2);
        cur_req = "R8"; block_msg(8'h22, 8'd33, 2);

        cur_req = "R9"; word_msg(8'h0C, 3);
        cur_req = "R9"; word_msg(8'h0D, 2);
        cur_req = "R9";
        send(K_AW, 8'h16); send(K_BY, 8'h08); send(K_AR, 8'h17);
        send(K_BY, 8'h55); send(K_SP, 0); gap(2);
        cur_req = "R10"; drain();
        cur_req = "R10"; word_msg(8'h0E, 2); drain();

        cur_req = "R12"; send(K_BY, 8'h12); gap(1);
        cur_req = "R12"; send(K_AR, 8'h17); gap(1);

        cur_req = "R13";
        send(K_AW, 8'h16); send(K_BY, 8'h05); send(K_BY, 8'h01);
        send(K_AW, 8'h16); gap(1);
        cur_req = "R13";
        send(K_AW, 8'h16); send(K_AR, 8'h17); gap(1);
        cur_req = "R13";
        send(K_AW, 8'h16); send(K_BY, 8'h2A); send(K_AR, 8'h17); gap(2);
        cur_req = "R2"; word_msg(8'h00, 2); drain();

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule